// File: doc/BRIEF.md
# Sparse Broadcast Multiply-Accumulate Cluster

This block is a row of processing elements that share one stream of compressed input values. Every element keeps its weight vector resident in two parts. A packed store holds only the nonzero weights. A bitmap holds one flag per original weight position, set where the weight is nonzero. Every element also keeps one partial sum that never leaves it while a vector is in progress.

The input stream carries only nonzero values. Each value comes with a 4-bit zero-run code, and the last value of a vector carries an end marker. A shared controller converts the run code into an absolute position and broadcasts it with the value to all elements. Each element checks its own bitmap at that position. It finds the packed address of the weight by counting the set flags in front of it, and it accumulates only where the flag is set. When the end marker is taken, every element presents its sum clipped to signed 16 bits, so the cluster yields one output row per input vector. The accumulators and the position then start again from zero, and the weights stay in place.

Weights are written through a simple load port: one whole bitmap per write, or one packed weight per write at a given packed address.

Top module: `sparse_bcast_cluster`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The first element of a vector sits at position equal to its run code. Each later element sits at the previous position plus its run code plus one.
- R3: For each element i, the output is the sum, over the accepted values, of value times the weight of element i at that value's position. The weight is fetched from the packed store at an address equal to the number of set bitmap flags below that position.
- R4: A value whose position has bitmap flag 0 adds nothing to that element's sum, even when the packed store holds nonzero weights.
- R5: The cycle after an input with `in_eov`=1 is accepted, `out_valid` is 1. Element i's result sits in `out_row[16*i +: 16]`.
- R6: After a row has been emitted, the next vector starts with zero sums and position zero, and it uses the same resident weights.
- R7: A sum above 32767 is output as 32767, and a sum below -32768 is output as -32768.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, `out_valid` stays 1 and `out_row` is unchanged.
- R9: A value whose position is 64 or more (beyond the vector length) contributes nothing to any element.
- R10: A bitmap write (`ld_bmap_we`) replaces the whole bitmap of element `ld_pe`. A weight write (`ld_wt_we`) stores `ld_wt` at packed address `ld_addr` of element `ld_pe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_pe | input | 4 | Element selected by a load |
| ld_bmap_we | input | 1 | Write the whole bitmap of the selected element |
| ld_bmap | input | 64 | Bitmap value, bit p is the flag of position p |
| ld_wt_we | input | 1 | Write one packed weight |
| ld_addr | input | 6 | Packed weight address |
| ld_wt | input | 16 | Signed packed weight |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Cluster can take an input element |
| in_run | input | 4 | Zeros preceding this value |
| in_val | input | 16 | Signed nonzero input value |
| in_eov | input | 1 | This value is the last of its vector |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Output row taken |
| out_row | output | 256 | Sixteen signed 16-bit results, element 0 lowest |

## Verification
The hardest case to reach is a packed address that must skip several set flags hidden inside a long zero run. This matters when the skipped positions lie near or past the end of the vector, where a wrong skip count or a missing range guard would pull in a neighbouring packed weight. The weight pattern gives every element a different, dense flag layout. The stimulus table contains vectors made of maximum runs that walk to position 63 and then past 64. Every result is compared against a dense dot product, so any misplaced packed address shows up as a wrong sum.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int RUN_W = 4;
    localparam int RUN_MAX = (1 << RUN_W) - 1;

    // Clamp a wide signed value to the range of a w-bit signed number.
    function automatic longint clip_signed(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int NUM_PE  = 16,
    parameter int VEC_LEN = 64,
    parameter int POS_W   = $clog2(VEC_LEN) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RUN_W-1:0]  in_run,
    input  logic              in_eov,
    input  logic [NUM_PE-1:0] pe_ready,
    output logic              in_ready,
    output logic              fire,
    output logic [POS_W-1:0]  ptr,
    output logic [POS_W-1:0]  pos
);

    typedef struct packed {
        logic [POS_W-1:0] ptr;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        in_ready = &pe_ready;
        fire     = in_valid && in_ready;
        pos      = cur_q.ptr + POS_W'(in_run);
        if (fire) begin
            if (in_eov) begin
                nxt_d.ptr = '0;
            end else if (pos >= POS_W'(VEC_LEN)) begin
                nxt_d.ptr = POS_W'(VEC_LEN);
            end else begin
                nxt_d.ptr = pos + POS_W'(1);
            end
        end
        ptr = cur_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/sbc_pe.sv
module sbc_pe
    import sbc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 40,
    parameter int VEC_LEN = 64,
    parameter int WT_DEPTH = 64,
    parameter int POS_W   = $clog2(VEC_LEN) + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bmap_we,
    input  logic [VEC_LEN-1:0]          bmap_in,
    input  logic                        wt_we,
    input  logic [$clog2(WT_DEPTH)-1:0] wt_addr,
    input  logic [DATA_W-1:0]           wt_in,
    input  logic                        fire,
    input  logic                        eov,
    input  logic [DATA_W-1:0]           in_val,
    input  logic [RUN_W-1:0]            run,
    input  logic [POS_W-1:0]            ptr,
    input  logic [POS_W-1:0]            pos,
    input  logic                        out_ready,
    output logic                        ready,
    output logic                        res_valid,
    output logic [DATA_W-1:0]           res
);

    localparam int BM_IW = $clog2(VEC_LEN);
    localparam int WA_W  = $clog2(WT_DEPTH);
    localparam int AW    = POS_W;
    localparam int PW    = 2 * DATA_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [AW-1:0]           waddr;
        logic [DATA_W-1:0]       res;
        logic                    res_valid;
    } pe_t;

    pe_t cur_q, nxt_d;

    logic [VEC_LEN-1:0] bmap_q;
    logic [DATA_W-1:0]  wmem_q [WT_DEPTH];

    logic [AW-1:0]           skip_cnt;
    logic [AW-1:0]           addr_here;
    logic                    hit;
    logic signed [DATA_W-1:0] wt;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] acc_sum;

    always_comb begin
        nxt_d = cur_q;

        // Count the set flags among the positions the zero run jumps over.
        skip_cnt = '0;
        for (int k = 0; k < RUN_MAX; k++) begin
            logic [POS_W-1:0] idx;
            idx = ptr + POS_W'(k);
            if ((RUN_W'(k) < run) && (idx < POS_W'(VEC_LEN))) begin
                skip_cnt = skip_cnt + AW'(bmap_q[idx[BM_IW-1:0]]);
            end
        end

        addr_here = cur_q.waddr + skip_cnt;
        hit = (pos < POS_W'(VEC_LEN)) && bmap_q[pos[BM_IW-1:0]];
        wt  = (addr_here < AW'(WT_DEPTH)) ? $signed(wmem_q[addr_here[WA_W-1:0]]) : '0;
        prod = $signed(in_val) * wt;
        acc_sum = cur_q.acc + (hit ? {{(ACC_W-PW){prod[PW-1]}}, prod} : '0);

        if (cur_q.res_valid && out_ready) begin
            nxt_d.res_valid = 1'b0;
        end

        if (fire) begin
            if (eov) begin
                nxt_d.res       = DATA_W'(clip_signed(longint'(acc_sum), DATA_W));
                nxt_d.res_valid = 1'b1;
                nxt_d.acc       = '0;
                nxt_d.waddr     = '0;
            end else begin
                nxt_d.acc   = acc_sum;
                nxt_d.waddr = addr_here + AW'(hit);
            end
        end

        ready     = !cur_q.res_valid;
        res_valid = cur_q.res_valid;
        res       = cur_q.res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            bmap_q <= '0;
        end else begin
            cur_q <= nxt_d;
            if (bmap_we) begin
                bmap_q <= bmap_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wt_we) begin
            wmem_q[wt_addr] <= wt_in;
        end
    end

endmodule

// File: rtl/sparse_bcast_cluster.sv
module sparse_bcast_cluster
    import sbc_pkg::*;
#(
    parameter int NUM_PE   = 16,
    parameter int DATA_W   = 16,
    parameter int ACC_W    = 40,
    parameter int VEC_LEN  = 64,
    parameter int WT_DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_PE)-1:0]   ld_pe,
    input  logic                        ld_bmap_we,
    input  logic [VEC_LEN-1:0]          ld_bmap,
    input  logic                        ld_wt_we,
    input  logic [$clog2(WT_DEPTH)-1:0] ld_addr,
    input  logic [DATA_W-1:0]           ld_wt,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [RUN_W-1:0]            in_run,
    input  logic [DATA_W-1:0]           in_val,
    input  logic                        in_eov,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [NUM_PE*DATA_W-1:0]    out_row
);

    localparam int POS_W = $clog2(VEC_LEN) + 2;
    localparam int PE_IW = $clog2(NUM_PE);

    logic [NUM_PE-1:0] pe_ready;
    logic [NUM_PE-1:0] pe_valid;
    logic              fire;
    logic [POS_W-1:0]  ptr;
    logic [POS_W-1:0]  pos;

    sbc_ctrl #(
        .NUM_PE  (NUM_PE),
        .VEC_LEN (VEC_LEN),
        .POS_W   (POS_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_run   (in_run),
        .in_eov   (in_eov),
        .pe_ready (pe_ready),
        .in_ready (in_ready),
        .fire     (fire),
        .ptr      (ptr),
        .pos      (pos)
    );

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic sel;
        assign sel = (ld_pe == PE_IW'(i));

        sbc_pe #(
            .DATA_W   (DATA_W),
            .ACC_W    (ACC_W),
            .VEC_LEN  (VEC_LEN),
            .WT_DEPTH (WT_DEPTH),
            .POS_W    (POS_W)
        ) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .bmap_we   (ld_bmap_we && sel),
            .bmap_in   (ld_bmap),
            .wt_we     (ld_wt_we && sel),
            .wt_addr   (ld_addr),
            .wt_in     (ld_wt),
            .fire      (fire),
            .eov       (in_eov),
            .in_val    (in_val),
            .run       (in_run),
            .ptr       (ptr),
            .pos       (pos),
            .out_ready (out_ready),
            .ready     (pe_ready[i]),
            .res_valid (pe_valid[i]),
            .res       (out_row[i*DATA_W +: DATA_W])
        );
    end

    assign out_valid = &pe_valid;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int NUM_PE = 16,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     in_eov,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [NUM_PE*DATA_W-1:0] out_row
);

    // R8: no new input while a row waits
    a_r8_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8: a waiting row is held
    a_r8_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    // R5: end marker accepted gives a row next cycle
    a_r5_row_after_eov: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eov) |=> out_valid);

    // R5: a row appears only after an accepted end marker
    a_r5_row_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_eov));

    // R8: a row leaves only when taken
    a_r8_row_leaves_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready));

endmodule

bind sparse_bcast_cluster sbc_checker #(
    .NUM_PE (NUM_PE),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eov    (in_eov),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row)
);

// File: tb/sparse_bcast_cluster_bench.sv
module sparse_bcast_cluster_bench;

    localparam int NPE = 16;
    localparam int VL  = 64;
    localparam int NST = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ld_pe = '0;
    logic        ld_bmap_we = 1'b0;
    logic [63:0] ld_bmap = '0;
    logic        ld_wt_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [15:0] ld_wt = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_run = '0;
    logic [15:0] in_val = '0;
    logic        in_eov = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [NPE*16-1:0] out_row;

    int checks = 0;
    int fails = 0;
    int wt [NPE][VL];

    always #5 clk = ~clk;

    sparse_bcast_cluster u_sparse_bcast_cluster (.*);

    // {eov, run, value}
    localparam logic [20:0] STIM [NST] = '{
        {1'b0, 4'd0,  16'sd100},  {1'b0, 4'd2, -16'sd3},
        {1'b0, 4'd0,  16'sd7},    {1'b1, 4'd5,  16'sd250},
        {1'b0, 4'd1, -16'sd1000}, {1'b0, 4'd3,  16'sd1},
        {1'b0, 4'd15, 16'sd9},    {1'b1, 4'd15,-16'sd7},
        {1'b0, 4'd15, 16'sd11},   {1'b0, 4'd15, 16'sd12},
        {1'b0, 4'd15,-16'sd5},    {1'b0, 4'd15, 16'sd20},
        {1'b1, 4'd15, 16'sd13},
        {1'b1, 4'd7,  16'sd32767},
        {1'b0, 4'd0,  16'sd1},    {1'b0, 4'd0,  16'sd2},
        {1'b0, 4'd0,  16'sd3},    {1'b0, 4'd0,  16'sd4},
        {1'b0, 4'd0,  16'sd5},    {1'b0, 4'd0,  16'sd6},
        {1'b1, 4'd0, -16'sd8}
    };

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_all();
        for (int e = 0; e < NPE; e++) begin
            logic [63:0] bm;
            int n;
            bm = '0;
            n = 0;
            for (int p = 0; p < VL; p++) begin
                if (wt[e][p] != 0) begin
                    bm[p] = 1'b1;
                    @(negedge clk);
                    ld_pe = 4'(e); ld_wt_we = 1'b1; ld_addr = 6'(n); ld_wt = 16'(wt[e][p]);
                    n++;
                end
            end
            // R4: spare packed slots hold junk that must never be used
            for (int a = n; a < VL; a++) begin
                @(negedge clk);
                ld_pe = 4'(e); ld_wt_we = 1'b1; ld_addr = 6'(a); ld_wt = 16'sd999;
            end
            @(negedge clk);
            ld_wt_we = 1'b0; ld_bmap_we = 1'b1; ld_bmap = bm;
            @(negedge clk);
            ld_bmap_we = 1'b0;
        end
    endtask

    task automatic send(input logic [3:0] r, input logic [15:0] v, input logic e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_run = r; in_val = v; in_eov = e;
        @(negedge clk);
        in_valid = 1'b0; in_eov = 1'b0;
    endtask

    task automatic check_row(input longint acc [NPE], input string req);
        check({req, " out_valid"}, longint'(out_valid), 1);
        for (int e = 0; e < NPE; e++) begin
            check(req, longint'($signed(out_row[e*16 +: 16])), sbc_pkg::clip_signed(acc[e], 16));
        end
    endtask

    task automatic take_row();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Send table entries a..b as one vector, model it densely, check the row.
    task automatic run_vec(input int a, input int b, input string req);
        longint acc [NPE];
        int p;
        p = -1;
        for (int e = 0; e < NPE; e++) acc[e] = 0;
        for (int i = a; i <= b; i++) begin
            p = p + 1 + int'(STIM[i][19:16]);
            if (p < VL) begin
                for (int e = 0; e < NPE; e++)
                    acc[e] += longint'($signed(STIM[i][15:0])) * longint'(wt[e][p]);
            end
            send(STIM[i][19:16], STIM[i][15:0], STIM[i][20]);
        end
        check_row(acc, req);
        take_row();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int e = 0; e < NPE; e++)
            for (int p = 0; p < VL; p++)
                wt[e][p] = (((p * 3 + e) % 4) != 0) ? ((e + 1) * 37 - p * 11) : 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 in_ready", longint'(in_ready), 1);
        rst_n = 1'b1;

        // R10: load bitmaps and packed weights
        load_all();

        // R2 R3 R4: short runs and a mix of signs
        run_vec(0, 3, "R3 vec0");
        // R6: second vector on the same weights with cleared sums
        run_vec(4, 7, "R6 vec1");
        // R9: maximum runs walking to position 63, then past the end
        run_vec(8, 12, "R9 long runs");
        // R2: single element vector at position 7
        run_vec(13, 13, "R2 single");
        // R3: dense run of zero codes
        run_vec(14, 20, "R3 dense");

        // R8: stalled row is held and blocks input
        begin
            longint acc [NPE];
            logic [NPE*16-1:0] snap;
            for (int e = 0; e < NPE; e++) acc[e] = 3 * longint'(wt[e][2]);
            send(4'd2, 16'sd3, 1'b1);
            snap = out_row;
            repeat (3) @(negedge clk);
            check("R8 in_ready low", longint'(in_ready), 0);
            check("R8 out_valid held", longint'(out_valid), 1);
            check("R8 row stable", longint'(out_row == snap), 1);
            check_row(acc, "R8 row");
            take_row();
            check("R8 released", longint'(out_valid), 0);
            check("R8 ready again", longint'(in_ready), 1);
        end

        // R7: saturation in both directions after a reload (R10)
        for (int p = 0; p < VL; p++) begin
            wt[0][p] = 32767;
            wt[1][p] = -32768;
        end
        load_all();
        begin
            longint acc [NPE];
            for (int e = 0; e < NPE; e++)
                acc[e] = 32767 * longint'(wt[e][0] + wt[e][1] + wt[e][2] + wt[e][3]);
            for (int i = 0; i < 4; i++) send(4'd0, 16'sd32767, 1'(i == 3));
            check("R7 high clip", longint'($signed(out_row[15:0])), 32767);
            check("R7 low clip", longint'($signed(out_row[31:16])), -32768);
            check_row(acc, "R7 row");
            take_row();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule